// File: doc/BRIEF.md
# Shared Banked Instruction Cache

This block is a read-only first-level instruction store that several compute-unit fetch front ends share. Each requestor port presents a byte address. When the cache accepts it, the port receives the aligned 32-byte half of a 64-byte line one cycle later. The store holds 32 KB. It is organised as 128 sets of four ways, and the two low set-index bits pick one of four banks. Lines that follow each other in the address space therefore land in different banks, and requests to different banks are all accepted in the same cycle.

When several ports aim at one bank in the same cycle, a rotating arbiter for that bank admits one of them. The others see ready low and keep their request up. When a request is admitted but its tag misses, the cache asks the next-level cache for that single 64-byte line, with no prefetch. It allows one such fill at a time. The line comes back as two 32-byte beats, and the cache writes it into a way chosen first among the set's empty ways and otherwise by a tree pseudo-LRU. Any port stalled on that line then hits on its retry. An invalidate-all input clears every valid bit in one cycle.

Top module: `icache_shared`

## Requirements
- R1: A request is accepted in the cycle that req_valid and req_ready are both high. In the following cycle rsp_valid for that port is high and rsp_data carries bytes [a&~31, a|31] of the addressed line. Address bit 5 selects the upper beat. A request that hits is accepted in its first cycle.
- R2: On a miss the cache raises fill_req_valid with the 64-byte-aligned line address and holds it until fill_req_ready. It expects two fill_rsp_valid beats, lower 32 bytes first, and installs the line. The retried fetch then returns the filled data.
- R3: Ports whose addresses fall in different banks (bank = address bits [7:6]) and that hit are all given req_ready in the same cycle. req_ready is never high for a port whose req_valid is low.
- R4: At most one port per bank gets req_ready in a cycle. Rotating priority serves N ports that contend for one bank in N consecutive cycles.
- R5: Only one line fill is outstanding at a time. Ports that miss on the same line together cause exactly one fill request. A new request is never raised before both beats of the previous fill have arrived.
- R6: A fill uses the lowest invalid way of the set. When all four ways are valid it evicts the tree pseudo-LRU way. After lines A, B, C and D are filled into one empty set in that order, a fifth line E evicts A and keeps B.
- R7: A one-cycle inv_all pulse clears every valid bit. No port is ready in the next cycle, and a line that hit before the pulse misses afterwards.
- R8: After reset, rsp_valid and fill_req_valid are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear all valid bits |
| req_valid | input | NUM_PORTS | Fetch request per port |
| req_addr | input | NUM_PORTS x ADDR_W | Fetch byte address per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle |
| rsp_valid | output | NUM_PORTS | Fetch data valid (one cycle after accept) |
| rsp_data | output | NUM_PORTS x 256 | 32-byte instruction chunk |
| fill_req_valid | output | 1 | Line fill request |
| fill_req_addr | output | ADDR_W | Line-aligned fill address |
| fill_req_ready | input | 1 | Next level accepts fill request |
| fill_rsp_valid | input | 1 | Fill beat valid |
| fill_rsp_data | input | 256 | Fill beat data |

## Verification
Two things are hardest to bring about from the ports. The first is a second port missing on a line whose fill is already in flight. The second is a set whose four ways are all valid, so that the pseudo-LRU order decides the victim. For the first, the bench starts two fetches of one uncached line in the same cycle and counts the requests that reach the behavioural next level. For the second, it fills one set with four lines 8 KB apart and then touches a fifth. The fill counter then shows which earlier line was dropped.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_REQ,
        FILL_BEAT0,
        FILL_BEAT1
    } fill_state_e;

    // 4-way tree: bit0 root (0 = victim on ways 0/1), bit1 left pair, bit2 right pair
    function automatic logic [1:0] plru_victim(input logic [2:0] t);
        if (!t[0]) return {1'b0, t[1]};
        return {1'b1, t[2]};
    endfunction

    function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] way);
        logic [2:0] r;
        r = t;
        if (!way[1]) begin
            r[0] = 1'b1;
            r[1] = ~way[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~way[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/icache_rr_arb.sv
module icache_rr_arb #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt
);
    localparam int PW = (NP > 1) ? $clog2(NP) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        logic found;
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int off = 0; off < NP; off++) begin
            int idx;
            idx = (int'(st_q.ptr) + off) % NP;
            if (!found && req[idx]) begin
                found      = 1'b1;
                gnt[idx]   = 1'b1;
                st_d.ptr   = PW'((idx + 1) % NP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icache_tag_match.sv
module icache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 19
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way
);
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && way_tag[w] == tag) begin
                hit     = 1'b1;
                hit_way = ($clog2(WAYS))'(w);
            end
        end
    end
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int WAY_W  = 2,
    parameter int BEAT_W = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [WAY_W-1:0]    start_way,
    output logic                busy,
    output logic                fill_req_valid,
    output logic [ADDR_W-1:0]   fill_req_addr,
    input  logic                fill_req_ready,
    input  logic                fill_rsp_valid,
    input  logic [BEAT_W-1:0]   fill_rsp_data,
    output logic                install_en,
    output logic [ADDR_W-1:0]   install_addr,
    output logic [WAY_W-1:0]    install_way,
    output logic [2*BEAT_W-1:0] install_data
);
    typedef struct packed {
        fill_state_e        state;
        logic [ADDR_W-1:0]  line;
        logic [WAY_W-1:0]   way;
        logic [BEAT_W-1:0]  beat0;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        install_en = 1'b0;
        unique case (st_q.state)
            FILL_IDLE: if (start) begin
                st_d.line  = {start_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                st_d.way   = start_way;
                st_d.state = FILL_REQ;
            end
            FILL_REQ:   if (fill_req_ready) st_d.state = FILL_BEAT0;
            FILL_BEAT0: if (fill_rsp_valid) begin
                st_d.beat0 = fill_rsp_data;
                st_d.state = FILL_BEAT1;
            end
            FILL_BEAT1: if (fill_rsp_valid) begin
                install_en = 1'b1;
                st_d.state = FILL_IDLE;
            end
            default: st_d.state = FILL_IDLE;
        endcase
    end

    assign busy           = (st_q.state != FILL_IDLE);
    assign fill_req_valid = (st_q.state == FILL_REQ);
    assign fill_req_addr  = st_q.line;
    assign install_addr   = st_q.line;
    assign install_way    = st_q.way;
    assign install_data   = {fill_rsp_data, st_q.beat0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= FILL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/icache_shared.sv
module icache_shared
    import icache_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int ADDR_W     = 32,
    parameter int CAPACITY   = 32768,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 32,
    parameter int WAYS       = 4,
    parameter int NUM_BANKS  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 inv_all,
    input  logic [NUM_PORTS-1:0]                 req_valid,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     req_addr,
    output logic [NUM_PORTS-1:0]                 req_ready,
    output logic [NUM_PORTS-1:0]                 rsp_valid,
    output logic [NUM_PORTS-1:0][BEAT_BYTES*8-1:0] rsp_data,
    output logic                                 fill_req_valid,
    output logic [ADDR_W-1:0]                    fill_req_addr,
    input  logic                                 fill_req_ready,
    input  logic                                 fill_rsp_valid,
    input  logic [BEAT_BYTES*8-1:0]              fill_rsp_data
);
    localparam int SETS   = CAPACITY / (LINE_BYTES * WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W = BEAT_BYTES * 8;
    localparam int BSEL   = $clog2(BEAT_BYTES);

    // storage
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [2:0]                 plru_q  [SETS];
    logic [BEAT_W-1:0]          data_q  [SETS*WAYS*BEATS];

    // per-port decode
    logic [NUM_PORTS-1:0][SET_W-1:0]  p_set;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  p_tag;
    logic [NUM_PORTS-1:0][BANK_W-1:0] p_bank;
    logic [NUM_PORTS-1:0]             p_beat;
    logic [NUM_PORTS-1:0]             p_hit;
    logic [NUM_PORTS-1:0][WAY_W-1:0]  p_way;
    logic [NUM_PORTS-1:0]             p_gnt;

    logic [NUM_BANKS-1:0][NUM_PORTS-1:0] bank_req, bank_gnt;

    // miss / fill
    logic                busy, miss_found, miss_start;
    logic [ADDR_W-1:0]   miss_addr;
    logic [WAY_W-1:0]    miss_way;
    logic                install_en;
    logic [ADDR_W-1:0]   install_addr;
    logic [WAY_W-1:0]    install_way;
    logic [2*BEAT_W-1:0] install_data;
    logic [SET_W-1:0]    inst_set;

    typedef struct packed {
        logic [NUM_PORTS-1:0]             valid;
        logic [NUM_PORTS-1:0][BEAT_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    genvar gp, gb;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            assign p_set[gp]  = req_addr[gp][OFF_W +: SET_W];
            assign p_tag[gp]  = req_addr[gp][ADDR_W-1 -: TAG_W];
            assign p_bank[gp] = req_addr[gp][OFF_W +: BANK_W];
            assign p_beat[gp] = req_addr[gp][BSEL];
            icache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
                .way_valid (valid_q[p_set[gp]]),
                .way_tag   (tag_q[p_set[gp]]),
                .tag       (p_tag[gp]),
                .hit       (p_hit[gp]),
                .hit_way   (p_way[gp])
            );
        end
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            icache_rr_arb #(.NP(NUM_PORTS)) u_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (bank_req[gb]),
                .gnt   (bank_gnt[gb])
            );
        end
    endgenerate

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            for (int p = 0; p < NUM_PORTS; p++)
                bank_req[b][p] = req_valid[p] && (int'(p_bank[p]) == b);
        p_gnt = '0;
        for (int b = 0; b < NUM_BANKS; b++) p_gnt = p_gnt | bank_gnt[b];
        req_ready = req_valid & p_gnt & p_hit;

        miss_found = 1'b0;
        miss_addr  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (!miss_found && req_valid[p] && p_gnt[p] && !p_hit[p]) begin
                miss_found = 1'b1;
                miss_addr  = req_addr[p];
            end
        end
        miss_start = miss_found && !busy && !inv_all;

        miss_way = plru_victim(plru_q[miss_addr[OFF_W +: SET_W]]);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_q[miss_addr[OFF_W +: SET_W]][w]) miss_way = WAY_W'(w);

        rsp_d.valid = req_ready;
        for (int p = 0; p < NUM_PORTS; p++)
            rsp_d.data[p] = data_q[(int'(p_set[p]) * WAYS + int'(p_way[p])) * BEATS
                                   + int'(p_beat[p])];
    end

    icache_fill_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .WAY_W  (WAY_W),
        .BEAT_W (BEAT_W)
    ) u_fill (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (miss_start),
        .start_addr     (miss_addr),
        .start_way      (miss_way),
        .busy           (busy),
        .fill_req_valid (fill_req_valid),
        .fill_req_addr  (fill_req_addr),
        .fill_req_ready (fill_req_ready),
        .fill_rsp_valid (fill_rsp_valid),
        .fill_rsp_data  (fill_rsp_data),
        .install_en     (install_en),
        .install_addr   (install_addr),
        .install_way    (install_way),
        .install_data   (install_data)
    );

    assign inst_set = install_addr[OFF_W +: SET_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                plru_q[s]  <= '0;
            end
        end else begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (req_ready[p]) plru_q[p_set[p]] <= plru_touch(plru_q[p_set[p]], p_way[p]);
            if (install_en)
                plru_q[inst_set] <= plru_touch(plru_q[inst_set], install_way);
            if (inv_all) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end else if (install_en) begin
                valid_q[inst_set][install_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install_en) begin
            tag_q[inst_set][install_way] <= install_addr[ADDR_W-1 -: TAG_W];
            for (int k = 0; k < BEATS; k++)
                data_q[(int'(inst_set) * WAYS + int'(install_way)) * BEATS + k]
                    <= install_data[k*BEAT_W +: BEAT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/icache_shared_chk.sv
module icache_shared_chk #(
    parameter int NUM_PORTS  = 4,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 32,
    parameter int NUM_BANKS  = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             inv_all,
    input logic [NUM_PORTS-1:0]             req_valid,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
    input logic [NUM_PORTS-1:0]             req_ready,
    input logic [NUM_PORTS-1:0]             rsp_valid,
    input logic                             fill_req_valid,
    input logic [ADDR_W-1:0]                fill_req_addr,
    input logic                             fill_req_ready,
    input logic                             fill_rsp_valid
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES;

    logic bank_clash;
    logic outstanding;
    int   beats_seen;

    always_comb begin
        bank_clash = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            int cnt;
            cnt = 0;
            for (int p = 0; p < NUM_PORTS; p++)
                if (req_ready[p] && int'(req_addr[p][OFF_W +: BANK_W]) == b) cnt++;
            if (cnt > 1) bank_clash = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            beats_seen  <= 0;
        end else if (fill_req_valid && fill_req_ready) begin
            outstanding <= 1'b1;
            beats_seen  <= 0;
        end else if (outstanding && fill_rsp_valid) begin
            if (beats_seen == BEATS - 1) outstanding <= 1'b0;
            beats_seen <= beats_seen + 1;
        end
    end

    assert_rsp_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid & req_ready)));

    assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));

    assert_one_grant_per_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_clash);

    assert_fill_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> (fill_req_addr[OFF_W-1:0] == '0));

    assert_fill_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

    assert_single_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !fill_req_valid);

    assert_no_hit_after_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (req_ready == '0));
endmodule

bind icache_shared icache_shared_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES),
    .NUM_BANKS  (NUM_BANKS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .inv_all        (inv_all),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_req_ready (fill_req_ready),
    .fill_rsp_valid (fill_rsp_valid)
);

// File: tb/icache_shared_tb.sv
module icache_shared_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 inv_all = 1'b0;
    logic [NP-1:0]        req_valid = '0;
    logic [NP-1:0][31:0]  req_addr = '0;
    logic [NP-1:0]        req_ready;
    logic [NP-1:0]        rsp_valid;
    logic [NP-1:0][255:0] rsp_data;
    logic                 fill_req_valid;
    logic [31:0]          fill_req_addr;
    logic                 fill_req_ready = 1'b0;
    logic                 fill_rsp_valid = 1'b0;
    logic [255:0]         fill_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int fill_count = 0;
    int overlap = 0;
    logic [31:0] last_fill = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_shared u_dut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_req_ready(fill_req_ready), .fill_rsp_valid(fill_rsp_valid),
        .fill_rsp_data(fill_rsp_data)
    );

    function automatic logic [255:0] beat_val(input logic [31:0] line, input int b);
        logic [255:0] v;
        for (int k = 0; k < 8; k++)
            v[k*32 +: 32] = (line ^ 32'hA5C3_0000) + 32'(b * 8 + k) * 32'h0101_0001;
        return v;
    endfunction

    function automatic logic [255:0] expect_chunk(input logic [31:0] a);
        return beat_val({a[31:6], 6'd0}, int'(a[5]));
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    endtask

    // behavioural next-level cache
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fill_req_valid) begin
                last_fill = fill_req_addr;
                fill_count++;
                fill_req_ready = 1'b1;
                @(negedge clk);
                fill_req_ready = 1'b0;
                if (fill_req_valid) overlap++;
                @(negedge clk);
                if (fill_req_valid) overlap++;
                fill_rsp_valid = 1'b1;
                fill_rsp_data  = beat_val(last_fill, 0);
                @(negedge clk);
                if (fill_req_valid) overlap++;
                fill_rsp_data  = beat_val(last_fill, 1);
                @(negedge clk);
                fill_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    task automatic fetch(input int p, input logic [31:0] a, output logic [255:0] d,
                         output int waited, output logic got);
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_addr[p]  = a;
        waited = 0;
        #1;
        while (!req_ready[p] && waited < 200) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        d   = rsp_data[p];
        got = rsp_valid[p];
        req_valid[p] = 1'b0;
    endtask

    task automatic test_reset();
        check(rsp_valid == '0, "R8 rsp_valid after reset", 256'(rsp_valid), 0);
        check(!fill_req_valid, "R8 fill_req_valid after reset", 256'(fill_req_valid), 0);
    endtask

    task automatic test_miss_then_hit();
        logic [255:0] d; int w; logic g; int c0;
        c0 = fill_count;
        fetch(0, 32'h0000_1008, d, w, g);
        check(fill_count == c0 + 1, "R8 cold line misses", 256'(fill_count - c0), 1);
        check(last_fill == 32'h0000_1000, "R2 fill address aligned", 256'(last_fill), 256'h1000);
        check(g && d == expect_chunk(32'h1008), "R2 filled lower beat", d, expect_chunk(32'h1008));
        fetch(0, 32'h0000_1020, d, w, g);
        check(fill_count == c0 + 1, "R1 hit issues no fill", 256'(fill_count - c0), 1);
        check(w == 0, "R1 hit accepted first cycle", 256'(w), 0);
        check(g && d == expect_chunk(32'h1020), "R1 upper beat data", d, expect_chunk(32'h1020));
    endtask

    task automatic test_parallel_banks();
        logic [255:0] d; int w; logic g;
        for (int b = 0; b < 4; b++) fetch(0, 32'(b * 64), d, w, g);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = 1'b1;
            req_addr[p]  = 32'(p * 64 + 32);
        end
        #1;
        check(req_ready == 4'hF, "R3 four banks ready together", 256'(req_ready), 256'hF);
        @(negedge clk);
        req_valid = '0;
        check(rsp_valid == 4'hF, "R1 four responses", 256'(rsp_valid), 256'hF);
        for (int p = 0; p < NP; p++)
            check(rsp_data[p] == expect_chunk(32'(p * 64 + 32)), "R3 per-port data",
                  rsp_data[p], expect_chunk(32'(p * 64 + 32)));
    endtask

    task automatic test_bank_conflict();
        logic [255:0] d; int w; logic g; logic [NP-1:0] served; int cycles; bit one;
        for (int k = 1; k < 4; k++) fetch(0, 32'(k * 256), d, w, g);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = 1'b1;
            req_addr[p]  = 32'(p * 256);
        end
        served = '0;
        cycles = 0;
        one = 1'b1;
        while (served != 4'hF && cycles < 10) begin
            logic [NP-1:0] r;
            #1;
            r = req_ready;
            if ($countones(r) != 1) one = 1'b0;
            served |= r;
            cycles++;
            @(negedge clk);
            req_valid = req_valid & ~r;
        end
        req_valid = '0;
        check(one, "R4 one grant per bank per cycle", 256'(one), 1);
        check(cycles == 4, "R4 four contenders served in four cycles", 256'(cycles), 4);
    endtask

    task automatic test_shared_miss();
        logic [255:0] d0, d1, d2, d3; int w0, w1, w2, w3; logic g0, g1, g2, g3; int c0;
        c0 = fill_count;
        fork
            fetch(0, 32'h0000_4000, d0, w0, g0);
            fetch(1, 32'h0000_4020, d1, w1, g1);
        join
        check(fill_count == c0 + 1, "R5 one fill for shared miss", 256'(fill_count - c0), 1);
        check(g0 && d0 == expect_chunk(32'h4000), "R5 port0 data", d0, expect_chunk(32'h4000));
        check(g1 && d1 == expect_chunk(32'h4020), "R5 port1 data", d1, expect_chunk(32'h4020));
        c0 = fill_count;
        fork
            fetch(2, 32'h0000_6040, d2, w2, g2);
            fetch(3, 32'h0000_60C0, d3, w3, g3);
        join
        check(fill_count == c0 + 2, "R5 two distinct misses", 256'(fill_count - c0), 2);
        check(overlap == 0, "R5 no overlapping fill request", 256'(overlap), 0);
        check(g3 && d3 == expect_chunk(32'h60C0), "R5 serialized miss data", d3,
              expect_chunk(32'h60C0));
    endtask

    task automatic test_plru();
        logic [255:0] d; int w; logic g; int c0;
        for (int k = 0; k < 5; k++) fetch(0, 32'h0000_0500 + 32'(k) * 32'h2000, d, w, g);
        c0 = fill_count;
        fetch(0, 32'h0000_2500, d, w, g);
        check(fill_count == c0, "R6 line B kept", 256'(fill_count - c0), 0);
        fetch(0, 32'h0000_0500, d, w, g);
        check(fill_count == c0 + 1, "R6 line A evicted", 256'(fill_count - c0), 1);
        check(d == expect_chunk(32'h0500), "R6 refilled data", d, expect_chunk(32'h0500));
    endtask

    task automatic test_invalidate();
        logic [255:0] d; int w; logic g; int c0;
        c0 = fill_count;
        fetch(1, 32'h0000_1000, d, w, g);
        check(fill_count == c0, "R7 hit before invalidate", 256'(fill_count - c0), 0);
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        fetch(1, 32'h0000_1000, d, w, g);
        check(fill_count == c0 + 1, "R7 miss after invalidate", 256'(fill_count - c0), 1);
        check(d == expect_chunk(32'h1000), "R7 refetch data", d, expect_chunk(32'h1000));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_miss_then_hit();
        test_parallel_banks();
        test_bank_conflict();
        test_shared_miss();
        test_plru();
        test_invalidate();
        repeat (5) @(negedge clk);
        report();
    end
endmodule